// File: doc/BRIEF.md
# Fast Ethernet link state monitor

This block decides whether a 100 Mb/s link is up. It watches the lock indication from the receive descrambler on a free-running symbol clock. The lock has to stay continuous for a long qualification window, about 50 ms in symbol clocks, before the link is declared up. Any loss of lock takes the link down on the next clock edge. A short glitch in lock therefore costs a full new qualification window.

The link state is reported three ways. A live bit follows the link. A latched-low bit records that a failure happened since the last status read. A sticky interrupt request flags every change of link state. When auto-negotiation is enabled, a link failure also sends a one-cycle restart request toward the negotiation logic.

The block also gates the transmit enable on its way to the line. Normally data passes only while the link is up. A diagnostic override lets data pass with the link down, but only when auto-negotiation is disabled. With auto-negotiation enabled and the link down, the block asks for fast link pulse bursts instead.

Top module: `fe_link_mon`

## Requirements
- R1: `link_up_o` goes high at the clock edge on which `lock_i` has been sampled high on QUAL_CYCLES consecutive edges. It does not go high on any earlier edge.
- R2: On any clock edge where `lock_i` is sampled low, `link_up_o` is 0 after that edge, and the lock run count restarts from zero. A relock therefore needs a full QUAL_CYCLES of continuous lock.
- R3: `link_latched_o` goes to 0 at the edge where the link falls. It stays 0 while `stat_rd_i` is low, even if the link comes back up.
- R4: At an edge with `stat_rd_i` high and no link fall, `link_latched_o` takes the link state in effect after that edge. A link fall at the same edge wins, and the bit is 0.
- R5: `irq_o` is set at every edge where the link rises or falls. It stays set until `irq_ack_i` is sampled high at an edge with no link change. A link change takes priority over the acknowledge.
- R6: `aneg_restart_o` is high for exactly one cycle, the first cycle after a link fall, when `aneg_en_i` is 1. It stays 0 when `aneg_en_i` is 0.
- R7: With the link up, `tx_en_o` equals `tx_en_i`, whatever the override input.
- R8: With the link down, `tx_en_o` equals `tx_en_i` only when `lfo_ovr_i`=1 and `aneg_en_i`=0. Otherwise `tx_en_o` is 0.
- R9: `flp_req_o` is 1 exactly when `aneg_en_i`=1 and the link is down.
- R10: After reset, `link_up_o`, `link_latched_o`, `irq_o` and `aneg_restart_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low reset |
| lock_i | input | 1 | Descrambler lock indication |
| aneg_en_i | input | 1 | Auto-negotiation enabled |
| lfo_ovr_i | input | 1 | Link-fail transmit override |
| tx_en_i | input | 1 | Transmit enable from the MAC |
| stat_rd_i | input | 1 | Status read strobe |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| link_up_o | output | 1 | Live link state |
| link_latched_o | output | 1 | Latched-low link state |
| irq_o | output | 1 | Sticky link-change interrupt request |
| aneg_restart_o | output | 1 | Auto-negotiation restart pulse |
| tx_en_o | output | 1 | Gated transmit enable |
| flp_req_o | output | 1 | Request for link pulse bursts |

## Verification
The checker watches a set of properties on every cycle:
- a sampled loss of lock always leaves the link down;
- a link rise always follows a cycle of lock;
- every link change leaves the interrupt set;
- a link fall always clears the latched bit;
- the restart pulse appears only right after a fall;
- transmission never passes while negotiation is enabled and the link is down.

Some behaviour depends on counting and on ordering, and only the bench scenarios can show it. This covers the exact cycle of qualification, the restart of the run after a partial lock, and the hold of the latched bit until a read. It also covers the priority of a link change over an acknowledge, and the full override truth table.

// File: rtl/fe_link_mon.sv
module fe_link_mon #(
  parameter int QUAL_CYCLES = 1250000,
  localparam int CW = $clog2(QUAL_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_i,
  input  logic aneg_en_i,
  input  logic lfo_ovr_i,
  input  logic tx_en_i,
  input  logic stat_rd_i,
  input  logic irq_ack_i,
  output logic link_up_o,
  output logic link_latched_o,
  output logic irq_o,
  output logic aneg_restart_o,
  output logic tx_en_o,
  output logic flp_req_o
);

  localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

  logic [CW-1:0] run_q;
  logic          link_q, link_d;
  logic          lat_q, irq_q, rst_pulse_q;
  logic          rise, fall;

  assign link_d = lock_i && (link_q || run_q == LAST);
  assign rise   = !link_q && link_d;
  assign fall   = link_q && !link_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= '0;
      link_q      <= 1'b0;
      lat_q       <= 1'b0;
      irq_q       <= 1'b0;
      rst_pulse_q <= 1'b0;
    end else begin
      if (!lock_i)           run_q <= '0;
      else if (run_q < LAST) run_q <= run_q + 1'b1;
      link_q      <= link_d;
      if (fall)           lat_q <= 1'b0;
      else if (stat_rd_i) lat_q <= link_d;
      if (rise || fall)   irq_q <= 1'b1;
      else if (irq_ack_i) irq_q <= 1'b0;
      rst_pulse_q <= fall && aneg_en_i;
    end
  end

  assign link_up_o      = link_q;
  assign link_latched_o = lat_q;
  assign irq_o          = irq_q;
  assign aneg_restart_o = rst_pulse_q;
  assign tx_en_o        = tx_en_i && (link_q || (lfo_ovr_i && !aneg_en_i));
  assign flp_req_o      = aneg_en_i && !link_q;

endmodule

// File: rtl/fe_link_mon_chk.sv
module fe_link_mon_chk (
  input logic clk,
  input logic rst_n,
  input logic lock_i,
  input logic aneg_en_i,
  input logic link_up_o,
  input logic link_latched_o,
  input logic irq_o,
  input logic aneg_restart_o,
  input logic tx_en_o
);

  // R2
  lock_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_i |=> !link_up_o);

  // R1
  rise_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up_o) |-> $past(lock_i));

  // R5
  irq_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(link_up_o) || $fell(link_up_o)) |-> irq_o);

  // R3
  latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_up_o) |-> !link_latched_o);

  // R6
  restart_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aneg_restart_o |-> (!link_up_o && $past(link_up_o)));

  // R8
  no_tx_in_aneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aneg_en_i && !link_up_o) |-> !tx_en_o);

endmodule

bind fe_link_mon fe_link_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .aneg_en_i(aneg_en_i),
  .link_up_o(link_up_o), .link_latched_o(link_latched_o), .irq_o(irq_o),
  .aneg_restart_o(aneg_restart_o), .tx_en_o(tx_en_o)
);

// File: tb/fe_link_mon_tb_top.sv
module fe_link_mon_tb_top;
  localparam int Q = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lock = 0, aneg = 1, ovr = 0, txi = 0, rd = 0, ack = 0;
  logic up, lat, irq, rstp, txo, flp;
  int   n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  fe_link_mon #(.QUAL_CYCLES(Q)) dut_i (
    .clk(clk), .rst_n(rst_n), .lock_i(lock), .aneg_en_i(aneg),
    .lfo_ovr_i(ovr), .tx_en_i(txi), .stat_rd_i(rd), .irq_ack_i(ack),
    .link_up_o(up), .link_latched_o(lat), .irq_o(irq),
    .aneg_restart_o(rstp), .tx_en_o(txo), .flp_req_o(flp)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R10 link", up, 0); chk("R10 latched", lat, 0);
    chk("R10 irq", irq, 0); chk("R10 restart", rstp, 0);
    chk("R9 flp at reset", flp, 1);
  endtask

  task automatic t_qualify;
    lock = 1; step(Q - 1);
    chk("R1 not early", up, 0);
    step(1);
    chk("R1 up at QUAL", up, 1); chk("R5 irq on rise", irq, 1);
    chk("R3 latched holds 0", lat, 0); chk("R9 flp off", flp, 0);
  endtask

  task automatic t_read_ack;
    rd = 1; step(1); rd = 0;
    chk("R4 read shows up", lat, 1);
    ack = 1; step(1); ack = 0;
    chk("R5 ack clears", irq, 0);
  endtask

  task automatic t_drop;
    lock = 0; step(1);
    chk("R2 drop", up, 0); chk("R3 latched cleared", lat, 0);
    chk("R6 restart pulse", rstp, 1); chk("R5 irq on fall", irq, 1);
    step(1);
    chk("R6 one cycle", rstp, 0);
  endtask

  task automatic t_partial;
    lock = 1; step(10); lock = 0; step(1); lock = 1;
    step(Q - 1);
    chk("R2 run restarted", up, 0);
    step(1);
    chk("R1 up after full relock", up, 1);
    chk("R3 latched still 0 without read", lat, 0);
  endtask

  task automatic t_tx;
    txi = 1; ovr = 1; aneg = 1; #1;
    chk("R7 tx passes when up", txo, 1);
    ovr = 0; #1; chk("R7 tx passes, no override", txo, 1);
    lock = 0; ack = 1; step(1); ack = 0;
    chk("R5 change beats ack", irq, 1);
    chk("R6 restart on fall", rstp, 1);
    chk("R8 no override blocks", txo, 0);
    ovr = 1; #1; chk("R8 aneg blocks override", txo, 0);
    chk("R9 flp requested", flp, 1);
    aneg = 0; #1; chk("R8 override passes", txo, 1);
    chk("R9 flp off without aneg", flp, 0);
    ovr = 0; #1; chk("R8 no override", txo, 0);
    txi = 0; ovr = 1; #1; chk("R8 follows tx_en", txo, 0);
    ovr = 0;
  endtask

  task automatic t_no_restart;
    rd = 1; step(1); rd = 0;
    chk("R4 read while down", lat, 0);
    lock = 1; step(Q); chk("R1 up again", up, 1);
    lock = 0; step(1);
    chk("R6 no restart without aneg", rstp, 0);
    chk("R2 down", up, 0);
  endtask

  initial begin
    step(2); rst_n = 1; step(1);
    t_reset(); t_qualify(); t_read_ack(); t_drop();
    t_partial(); t_tx(); t_no_restart();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule